// File: doc/BRIEF.md
# Status Register Write-Protect Unit

This block owns the eight-bit status byte of a serial memory and answers one question for the command engine that sits beside it: may this write go ahead? It holds the write-enable latch and mirrors the busy flag of the internal write cycle. It also keeps three retained protection bits in registers that the logic reset does not touch, which model nonvolatile cells. From these bits it forms the byte that a status read returns. It gives a permission answer for a status write and another for an array write at a given address.

The command engine decodes frames and presents them as pulses: set the latch, clear the latch, commit a status write with its data byte, and end of write cycle. Alongside these it supplies the busy level, the chip-select level and the write-protect pin. The block watches the pin against chip select so that it can cancel a status write whose frame saw the pin fall. The protected part of the array is a window at the top of the address space. It is sized by a two-bit level and scales with the array depth parameter.

Top module: `stat_guard`

## Requirements
- R1: The status byte is {lock_en, 3'b000, win[1:0], wel, busy}: bit 7 is the lock enable, bits 6 to 4 always read 0, bits 3:2 are the window level, bit 1 is the write-enable latch and bit 0 is the busy input.
- R2: After a logic reset the write-enable latch is 0. At power-up the retained bits are lock_en=0 and win=00.
- R3: A set pulse sets the latch on the next cycle if busy is low. A clear pulse or an end-of-cycle pulse clears it on the next cycle, whatever the pin level. A clear wins over a set in the same cycle.
- R4: An accepted status commit loads bits 7, 3 and 2 of the data byte into lock_en and win on the next cycle. All other status bits are unaffected.
- R5: A status commit while the latch is 0 changes nothing.
- R6: Hardware lock is active when wp_n is low and lock_en is 1. While it is active, stat_wr_ok is 0 and any status commit is refused.
- R7: If wp_n falls while cs_n is low, the next status commit is cancelled. The cancel is cleared by the next falling edge of cs_n. A fall of wp_n while cs_n is high has no effect.
- R8: arr_wr_ok is 1 only when the latch is 1, busy is 0, and the address is outside the window. Level 00 protects nothing. Level 01 protects addresses at or above 3*DEPTH/4. Level 10 protects addresses at or above DEPTH/2. Level 11 protects every address.
- R9: lock_en and win keep their values through a logic reset.
- R10: While busy is 1, stat_wr_ok and arr_wr_ok are 0, a status commit is refused, and a set pulse is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low logic reset |
| wel_set | input | 1 | Write-enable set pulse |
| wel_clr | input | 1 | Write-enable clear pulse |
| cyc_done | input | 1 | Internal write cycle finished pulse |
| busy | input | 1 | Internal write cycle in progress |
| sr_commit | input | 1 | Status write frame completed, apply sr_data |
| sr_data | input | 8 | Data byte of the status write |
| wp_n | input | 1 | Write-protect pin, active low |
| cs_n | input | 1 | Chip-select level, active low |
| arr_addr | input | AW | Array address to judge |
| status_byte | output | 8 | Byte returned by a status read |
| stat_wr_ok | output | 1 | A status write would be accepted now |
| arr_wr_ok | output | 1 | A write to arr_addr would be accepted now |

## Verification
A wrong latch or retained bit shows on status_byte one cycle after the pulse that caused it. It also flips stat_wr_ok or arr_wr_ok in that same cycle. A cancel flag that is stuck or never set stays hidden until the next status commit. At that commit, the retained bits in status_byte move when they should hold, or hold when they should move, one cycle later. For this reason the stimulus pairs pin falls inside and outside frames with commits that follow them.

// File: rtl/stat_pkg.sv
// Package: shared field positions and the window level encoding for the
// status write-protect unit. Assumes an eight-bit status byte.
package stat_pkg;
    localparam int unsigned SB_LOCK = 7;
    localparam int unsigned SB_WIN1 = 3;
    localparam int unsigned SB_WIN0 = 2;
    localparam int unsigned SB_WEL  = 1;
    localparam int unsigned SB_BUSY = 0;

    typedef enum logic [1:0] {
        WIN_NONE    = 2'b00,
        WIN_QUARTER = 2'b01,
        WIN_HALF    = 2'b10,
        WIN_ALL     = 2'b11
    } win_t;
endpackage

// File: rtl/stat_wel.sv
// Module: write-enable latch. Set by a set pulse when idle, cleared by the
// clear pulse or the end of a write cycle. Assumes pulses are one cycle wide.
module stat_wel (
    input  logic clk,
    input  logic rst_n,
    input  logic set_p,
    input  logic clr_p,
    input  logic done_p,
    input  logic busy,
    output logic wel
);
    // Latch update: clear has priority over set.
    always_ff @(posedge clk) begin
        if (!rst_n)                 wel <= 1'b0;
        else if (clr_p || done_p)   wel <= 1'b0;
        else if (set_p && !busy)    wel <= 1'b1;
    end

    p_clear_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_p || done_p) |=> !wel);
    p_set_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (set_p && !clr_p && !done_p && !busy) |=> wel);
    p_set_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !wel) |=> !wel);
endmodule

// File: rtl/stat_nv.sv
// Module: retained protection bits plus the pin-fall cancel tracker.
// The retained bits have no reset; their declaration value models the
// factory state. Assumes wp_n and cs_n are already synchronous to clk.
module stat_nv
    import stat_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       wp_n,
    input  logic       commit,
    input  logic [7:0] data,
    input  logic       wel,
    input  logic       busy,
    output logic       lock_en,
    output win_t       win,
    output logic       hw_lock,
    output logic       commit_ok
);
    logic [2:0] nv_q = 3'b000;
    logic       wp_q;
    logic       cs_q;
    logic       cancel_q;
    logic       wp_fall;
    logic       frame_start;

    assign lock_en     = nv_q[2];
    assign win         = win_t'(nv_q[1:0]);
    assign hw_lock     = lock_en && !wp_n;
    assign wp_fall     = wp_q && !wp_n;
    assign frame_start = cs_q && !cs_n;
    assign commit_ok   = commit && wel && !busy && !hw_lock && !cancel_q;

    // Edge history of the pin and chip select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q <= 1'b1;
            cs_q <= 1'b1;
        end else begin
            wp_q <= wp_n;
            cs_q <= cs_n;
        end
    end

    // Cancel flag: armed by a pin fall inside a frame, cleared at frame start.
    always_ff @(posedge clk) begin
        if (!rst_n)                   cancel_q <= 1'b0;
        else if (wp_fall && !cs_n)    cancel_q <= 1'b1;
        else if (frame_start)         cancel_q <= 1'b0;
    end

    // Retained bits: loaded only by an accepted commit, untouched by reset.
    always_ff @(posedge clk) begin
        if (rst_n && commit_ok)
            nv_q <= {data[SB_LOCK], data[SB_WIN1], data[SB_WIN0]};
    end

    p_nowel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !wel) |=> $stable(nv_q));
    p_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && hw_lock) |=> $stable(nv_q));
    p_cancel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && cancel_q) |=> $stable(nv_q));
    p_keep_r9: assert property (@(posedge clk)
        !rst_n |=> $stable(nv_q));
endmodule

// File: rtl/stat_window.sv
// Module: protected-window compare. The window starts at 3/4, 1/2 or 0 of
// DEPTH depending on the level. Assumes DEPTH is a power of two, at least 4.
module stat_window
    import stat_pkg::*;
#(
    parameter int unsigned DEPTH = 1024,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic [AW-1:0] addr,
    input  win_t          win,
    output logic          hit
);
    localparam logic [AW:0] QTR_BASE  = (AW+1)'((DEPTH / 4) * 3);
    localparam logic [AW:0] HALF_BASE = (AW+1)'(DEPTH / 2);

    logic [AW:0] addr_x;
    assign addr_x = {1'b0, addr};

    // Decode the level into a hit for this address.
    always_comb begin
        unique case (win)
            WIN_NONE:    hit = 1'b0;
            WIN_QUARTER: hit = (addr_x >= QTR_BASE);
            WIN_HALF:    hit = (addr_x >= HALF_BASE);
            default:     hit = 1'b1;
        endcase
    end
endmodule

// File: rtl/stat_guard.sv
// Module: top of the status write-protect unit. Forms the status byte and the
// two permission answers. Assumes the command engine supplies one-cycle pulses.
module stat_guard
    import stat_pkg::*;
#(
    parameter int unsigned DEPTH = 1024,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wel_set,
    input  logic          wel_clr,
    input  logic          cyc_done,
    input  logic          busy,
    input  logic          sr_commit,
    input  logic [7:0]    sr_data,
    input  logic          wp_n,
    input  logic          cs_n,
    input  logic [AW-1:0] arr_addr,
    output logic [7:0]    status_byte,
    output logic          stat_wr_ok,
    output logic          arr_wr_ok
);
    logic wel;
    logic lock_en;
    win_t win;
    logic hw_lock;
    logic commit_ok;
    logic win_hit;

    stat_wel u_wel (
        .clk(clk), .rst_n(rst_n), .set_p(wel_set), .clr_p(wel_clr),
        .done_p(cyc_done), .busy(busy), .wel(wel)
    );

    stat_nv u_nv (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wp_n(wp_n),
        .commit(sr_commit), .data(sr_data), .wel(wel), .busy(busy),
        .lock_en(lock_en), .win(win), .hw_lock(hw_lock), .commit_ok(commit_ok)
    );

    stat_window #(.DEPTH(DEPTH)) u_win (
        .addr(arr_addr), .win(win), .hit(win_hit)
    );

    // Status byte assembly with reserved bits held at zero.
    always_comb begin
        status_byte          = 8'h00;
        status_byte[SB_LOCK] = lock_en;
        status_byte[SB_WIN1] = win[1];
        status_byte[SB_WIN0] = win[0];
        status_byte[SB_WEL]  = wel;
        status_byte[SB_BUSY] = busy;
    end

    assign stat_wr_ok = wel && !busy && !hw_lock;
    assign arr_wr_ok  = wel && !busy && !win_hit;

    p_all_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (win == WIN_ALL) |-> !arr_wr_ok);
    p_busy_deny_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!stat_wr_ok && !arr_wr_ok));
    p_pin_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wp_n && status_byte[SB_LOCK]) |-> !stat_wr_ok);
    p_commit_unused_r4: assert property (@(posedge clk) disable iff (!rst_n)
        commit_ok |-> wel);
endmodule

// File: tb/sim_stat_guard.sv
module sim_stat_guard;
    localparam int unsigned DEPTH = 1024;
    localparam int unsigned AW = $clog2(DEPTH);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wel_set = 0, wel_clr = 0, cyc_done = 0, busy = 0, sr_commit = 0;
    logic [7:0] sr_data = 0;
    logic wp_n = 1, cs_n = 1;
    logic [AW-1:0] arr_addr = 0;
    logic [7:0] status_byte;
    logic stat_wr_ok, arr_wr_ok;

    int total = 0;
    int bad = 0;
    bit done_run = 0;

    always #2 clk = ~clk;

    stat_guard #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .wel_set(wel_set), .wel_clr(wel_clr),
        .cyc_done(cyc_done), .busy(busy), .sr_commit(sr_commit),
        .sr_data(sr_data), .wp_n(wp_n), .cs_n(cs_n), .arr_addr(arr_addr),
        .status_byte(status_byte), .stat_wr_ok(stat_wr_ok), .arr_wr_ok(arr_wr_ok)
    );

    // Reference state built from the requirements.
    logic       m_wel = 0, m_can = 0, m_wpq = 1, m_csq = 1;
    logic [2:0] m_nv = 3'b000;

    function automatic logic in_win(logic [AW-1:0] a, logic [1:0] lv);
        case (lv)
            2'b00: return 1'b0;
            2'b01: return int'(a) >= (DEPTH / 4) * 3;
            2'b10: return int'(a) >= DEPTH / 2;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [7:0] exp_status();
        return {m_nv[2], 3'b000, m_nv[1:0], m_wel, busy};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_wel <= 0; m_can <= 0; m_wpq <= 1; m_csq <= 1;
        end else begin
            if (wel_clr || cyc_done) m_wel <= 0;
            else if (wel_set && !busy) m_wel <= 1;
            if (sr_commit && m_wel && !busy && !(m_nv[2] && !wp_n) && !m_can)
                m_nv <= {sr_data[7], sr_data[3], sr_data[2]};
            if (m_wpq && !wp_n && !cs_n) m_can <= 1;
            else if (m_csq && !cs_n) m_can <= 0;
            m_wpq <= wp_n;
            m_csq <= cs_n;
        end
    end

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_model(string tag);
        check({tag, " R1 status"}, status_byte, exp_status());
        check({tag, " R6 stat_wr_ok"}, {7'b0, stat_wr_ok},
              {7'b0, m_wel && !busy && !(m_nv[2] && !wp_n)});
        check({tag, " R8 arr_wr_ok"}, {7'b0, arr_wr_ok},
              {7'b0, m_wel && !busy && !in_win(arr_addr, m_nv[1:0])});
    endtask

    task automatic step(string tag);
        @(posedge clk);
        @(negedge clk);
        #1;
        check_model(tag);
    endtask

    task automatic idle();
        wel_set = 0; wel_clr = 0; cyc_done = 0; sr_commit = 0;
    endtask

    initial begin
        #(200000 * 4);
        if (!done_run) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R2 reset status", status_byte, 8'h00);
        check("R2 reset stat_wr_ok", {7'b0, stat_wr_ok}, 8'h00);
        rst_n = 1;
        step("R2 idle");
        wel_set = 1; step("R3 set"); idle();
        check("R3 latch set", status_byte, 8'h02);
        sr_data = 8'hFF; sr_commit = 1; step("R4 commit"); idle();
        check("R4 only 7,3,2 load", status_byte, 8'h8E);
        arr_addr = 0; #1;
        check("R8 level 11 denies 0", {7'b0, arr_wr_ok}, 8'h00);
        wp_n = 0; sr_data = 8'h00; sr_commit = 1; step("R6 locked"); idle();
        check("R6 commit refused", status_byte, 8'h8E);
        check("R6 stat_wr_ok low", {7'b0, stat_wr_ok}, 8'h00);
        wel_clr = 1; step("R3 clear pin low"); idle();
        check("R3 clear with pin low", status_byte, 8'h8C);
        wp_n = 1; wel_set = 1; step("R3 set"); idle();
        sr_data = 8'h04; sr_commit = 1; step("R4 quarter"); idle();
        check("R4 level 01", status_byte, 8'h06);
        arr_addr = 767; #1;
        check("R8 767 open", {7'b0, arr_wr_ok}, 8'h01);
        arr_addr = 768; #1;
        check("R8 768 locked", {7'b0, arr_wr_ok}, 8'h00);
        sr_data = 8'h08; sr_commit = 1; step("R4 half"); idle();
        arr_addr = 511; #1;
        check("R8 511 open", {7'b0, arr_wr_ok}, 8'h01);
        arr_addr = 512; #1;
        check("R8 512 locked", {7'b0, arr_wr_ok}, 8'h00);
        cyc_done = 1; step("R3 done"); idle();
        check("R3 done clears", status_byte, 8'h08);
        sr_data = 8'h8C; sr_commit = 1; step("R5 no latch"); idle();
        check("R5 commit ignored", status_byte, 8'h08);
        wel_set = 1; step("R7 prep"); idle();
        cs_n = 0; step("R7 frame");
        wp_n = 0; step("R7 fall in frame");
        wp_n = 1; step("R7 pin back");
        cs_n = 1; sr_data = 8'h00; sr_commit = 1; step("R7 commit"); idle();
        check("R7 cancelled", status_byte, 8'h0A);
        cs_n = 0; step("R7 new frame");
        cs_n = 1; step("R7 end frame");
        wp_n = 0; step("R7 fall outside frame");
        wp_n = 1; sr_commit = 1; step("R7 commit ok"); idle();
        check("R7 cleared by frame start", status_byte, 8'h02);
        busy = 1; #1;
        check("R10 busy bit", status_byte, 8'h03);
        sr_data = 8'h0C; sr_commit = 1; step("R10 busy commit"); idle();
        check("R10 commit refused", status_byte, 8'h03);
        busy = 0; sr_data = 8'h8C; sr_commit = 1; step("R9 prep"); idle();
        rst_n = 0; step("R9 reset");
        rst_n = 1; #1;
        check("R9 retained bits", status_byte, 8'h8C);
        wel_set = 1; step("clean"); idle();
        sr_data = 8'h00; sr_commit = 1; step("clean"); idle();
        void'($urandom(32'h5eed));
        for (int i = 0; i < 4000; i++) begin
            wel_set   = ($urandom % 8) == 0;
            wel_clr   = ($urandom % 16) == 0;
            cyc_done  = ($urandom % 16) == 0;
            if (($urandom % 8) == 0) busy = ~busy;
            if (($urandom % 6) == 0) wp_n = ~wp_n;
            if (($urandom % 4) == 0) cs_n = ~cs_n;
            sr_commit = cs_n && (($urandom % 4) == 0);
            sr_data   = 8'($urandom);
            arr_addr  = AW'($urandom);
            rst_n     = ($urandom % 200) != 0;
            step("rand R3 R4 R5 R7 R9 R10");
        end
        done_run = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule